// File: doc/BRIEF.md
# L0 Filter Data Cache

This block is a small level-0 data cache that sits between a load/store unit and a 4-way set-associative L1 data cache. It holds eight 16-byte lines, direct-mapped, and is write-back. A per-PC predictor tries to guess which accesses will miss in L0. When it predicts a miss, the request skips the serial L0 lookup cycle and goes to L1 one cycle sooner. A cheap tag probe still runs on these requests, so an L0 copy that is present, and possibly dirty, always serves the access. Stale data can never come back from L1.

Data returned by L1 is not always allocated into L0. Each predictor entry carries a reuse flag. The flag is cleared when a line that the entry allocated is evicted without having been hit. While the flag is clear, the next fill from that entry is not allocated and the flag is set again, so allocation is retried on the miss after that. Every L0 line records the L1 way that returned it. A dirty victim is written back to exactly that way, with a flag that tells L1 to skip its tag compare.

The block serves one CPU request at a time. L1 answers every request with one response pulse. It may take any number of cycles to answer.

Top module: `l0_filter_dcache`

## Requirements
- R1: After reset the CPU port is ready, no response and no L1 request is active, every predictor counter is 0 (every request takes the lookup path), every reuse flag is set, and every L0 line is invalid.
- R2: A load that hits in L0 returns its 32-bit word in the cycle after acceptance, and no L1 request is issued for it.
- R3: A store that hits in L0 updates only the L0 word and marks the line dirty, with no L1 traffic. A later load of that word returns the stored value.
- R4: The predictor holds one 2-bit saturating counter per entry, indexed by PC bits [5:2]. The counter is incremented on an L0 miss and decremented on an L0 hit. A miss is predicted when the counter is 2 or 3.
- R5: On a miss, a request predicted to miss presents its first L1 request 2 cycles after acceptance. A request not predicted to miss presents it 3 cycles after acceptance, because it spends one extra cycle on the L0 lookup.
- R6: A request predicted to miss that does hit in L0 (load or store) is served by L0 in the cycle after acceptance, with no L1 request. A load therefore returns the latest stored value.
- R7: A load miss issues an L1 line read (op 0) to the line address. Its CPU response follows one cycle after the L1 response and carries the requested word.
- R8: A load-miss fill is allocated only if the requesting predictor entry's reuse flag is set. A fill that is not allocated leaves L0 unchanged and sets that flag. Replacing a valid line that was never hit clears the flag of the entry that allocated it.
- R9: Before an allocating fill replaces a dirty line, a line write (op 2) goes to the victim's line address, carrying the whole line, the L1 way number stored with the line, and the skip-tag flag set. The skip-tag flag is low on every other L1 request.
- R10: A store that misses in L0 is sent to L1 as a word write (op 1), with its byte address and the data in bits [31:0]. It is not allocated in L0.
- R11: Only one request is in flight at a time. Ready is low from the cycle after acceptance through the response cycle, and high again in the cycle after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Block can accept a request |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address (word aligned) |
| cpu_req_wdata | input | 32 | Store data |
| cpu_req_pc | input | 32 | PC of the load/store instruction |
| cpu_resp_valid | output | 1 | One-cycle response pulse |
| cpu_resp_rdata | output | 32 | Load data (0 for stores) |
| l1_req_valid | output | 1 | L1 request, held until the L1 response |
| l1_req_op | output | 2 | 0 line read, 1 word write, 2 line write |
| l1_req_addr | output | 32 | Line address, or byte address for a word write |
| l1_req_wdata | output | 128 | Line data, or word in bits [31:0] |
| l1_req_way | output | 2 | L1 way for a line write |
| l1_req_skip_tag | output | 1 | L1 skips its tag compare (line writes) |
| l1_resp_valid | input | 1 | L1 response pulse |
| l1_resp_rdata | input | 128 | Line returned by a line read |
| l1_resp_way | input | 2 | L1 way holding the returned line |

## Verification
Timing is counted from the cycle in which a request is accepted. A hit response is due 1 cycle later. A predicted-miss L1 request is due 2 cycles later and a lookup-path L1 request 3 cycles later. The response to a load miss without write-back is due 6 cycles after acceptance against a two-cycle L1 model. Every input is driven and every output sampled on the falling edge. The bench keeps a cycle counter that advances on the rising edge, and its L1 model logs the cycle in which each request first appears, so each check compares an exact cycle difference. Allocation and the no-traffic outcomes are observed through L1 request counts on later accesses.

// File: rtl/fdc_pkg.sv
// Shared types for the L0 filter data cache.
// Assumes: a single outstanding request; L1 responds once per request.
package fdc_pkg;

    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_DELAY = 3'd2,
        ST_WB    = 3'd3,
        ST_FILL  = 3'd4,
        ST_WORD  = 3'd5,
        ST_RESP  = 3'd6
    } fdc_state_t;

    // L1 request opcodes (the L1 side decodes these values)
    typedef enum logic [1:0] {
        L1_RD_LINE = 2'd0,
        L1_WR_WORD = 2'd1,
        L1_WR_LINE = 2'd2
    } l1_op_t;

endpackage

// File: rtl/fdc_predictor.sv
// Miss predictor and reuse flags, one entry per PC index.
// Each entry: 2-bit saturating counter (miss predicted at >= 2) and a
// reuse flag that allows L0 allocation. Assumes set and clear never
// target the same entry in one cycle (set has priority if they do).
module fdc_predictor #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    output logic             look_miss,
    output logic             look_reuse,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_hit,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx
);

    logic [1:0]         ctr [ENTRIES];
    logic [ENTRIES-1:0] reuse;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        // Counter: saturating step toward hit (down) or miss (up)
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctr[e] <= 2'd0;
            end else if (upd_en && upd_idx == IDX_W'(e)) begin
                if (upd_hit) begin
                    if (ctr[e] != 2'd0) ctr[e] <= ctr[e] - 2'd1;
                end else begin
                    if (ctr[e] != 2'd3) ctr[e] <= ctr[e] + 2'd1;
                end
            end
        end

        // Reuse flag: set after a suppressed fill, cleared on a wasted line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reuse[e] <= 1'b1;
            end else if (set_en && set_idx == IDX_W'(e)) begin
                reuse[e] <= 1'b1;
            end else if (clr_en && clr_idx == IDX_W'(e)) begin
                reuse[e] <= 1'b0;
            end
        end
    end

    // Read port: prediction and allocation permission of one entry
    always_comb begin
        look_miss  = ctr[look_idx][1];
        look_reuse = reuse[look_idx];
    end

endmodule

// File: rtl/fdc_lines.sv
// L0 line storage: per line valid, dirty, reused, tag, L1 way, owner
// predictor index and data. One combinational read port; word write,
// touch (mark reused) and full-line fill as write operations.
// Assumes at most one write operation per cycle.
module fdc_lines #(
    parameter int LINES  = 8,
    parameter int TAG_W  = 25,
    parameter int LINE_W = 128,
    parameter int WORD_W = 32,
    parameter int WAY_W  = 2,
    parameter int OWN_W  = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int WPL   = LINE_W / WORD_W,
    localparam int SEL_W = $clog2(WPL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic              rd_reused,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [WAY_W-1:0]  rd_way,
    output logic [OWN_W-1:0]  rd_owner,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              touch_en,
    input  logic [IDX_W-1:0]  touch_idx,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [OWN_W-1:0]  fill_owner,
    input  logic [LINE_W-1:0] fill_line
);

    logic [LINES-1:0]  valid, dirty, reused;
    logic [TAG_W-1:0]  tag   [LINES];
    logic [WAY_W-1:0]  way   [LINES];
    logic [OWN_W-1:0]  owner [LINES];
    logic [LINE_W-1:0] data  [LINES];

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic hit_wr, hit_touch, hit_fill;
        assign hit_wr    = wr_en    && wr_idx    == IDX_W'(l);
        assign hit_touch = touch_en && touch_idx == IDX_W'(l);
        assign hit_fill  = fill_en  && fill_idx  == IDX_W'(l);

        // State bits: fill resets, writes and touches mark the line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[l]  <= 1'b0;
                dirty[l]  <= 1'b0;
                reused[l] <= 1'b0;
            end else if (hit_fill) begin
                valid[l]  <= 1'b1;
                dirty[l]  <= 1'b0;
                reused[l] <= 1'b0;
            end else if (hit_wr) begin
                dirty[l]  <= 1'b1;
                reused[l] <= 1'b1;
            end else if (hit_touch) begin
                reused[l] <= 1'b1;
            end
        end

        // Tag, way, owner and data payload (no reset needed)
        always_ff @(posedge clk) begin
            if (hit_fill) begin
                tag[l]   <= fill_tag;
                way[l]   <= fill_way;
                owner[l] <= fill_owner;
                data[l]  <= fill_line;
            end else if (hit_wr) begin
                data[l][wr_sel*WORD_W +: WORD_W] <= wr_word;
            end
        end
    end

    // Read port for the indexed line
    always_comb begin
        rd_valid  = valid[rd_idx];
        rd_dirty  = dirty[rd_idx];
        rd_reused = reused[rd_idx];
        rd_tag    = tag[rd_idx];
        rd_way    = way[rd_idx];
        rd_owner  = owner[rd_idx];
        rd_line   = data[rd_idx];
    end

endmodule

// File: rtl/l0_filter_dcache.sv
// L0 filter data cache top: request register, controller FSM, predictor
// and line store. Predicted misses skip the lookup cycle but still probe
// the tag so a present line always serves the access. Load fills are
// allocated per the reuse flag; dirty victims are written back to the
// stored L1 way with the skip-tag flag. Assumes word-aligned accesses.
module l0_filter_dcache #(
    parameter int ADDR_W       = 32,
    parameter int WORD_W       = 32,
    parameter int LINES        = 8,
    parameter int LINE_BYTES   = 16,
    parameter int PRED_ENTRIES = 16,
    parameter int L1_WAYS      = 4,
    localparam int LINE_W = LINE_BYTES * 8,
    localparam int WPL    = LINE_W / WORD_W,
    localparam int SEL_W  = $clog2(WPL),
    localparam int BOFF_W = $clog2(WORD_W / 8),
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int IDX_W  = $clog2(LINES),
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
    localparam int PIDX_W = $clog2(PRED_ENTRIES),
    localparam int WAY_W  = $clog2(L1_WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [WORD_W-1:0] cpu_req_wdata,
    input  logic [ADDR_W-1:0] cpu_req_pc,
    output logic              cpu_resp_valid,
    output logic [WORD_W-1:0] cpu_resp_rdata,
    output logic              l1_req_valid,
    output logic [1:0]        l1_req_op,
    output logic [ADDR_W-1:0] l1_req_addr,
    output logic [LINE_W-1:0] l1_req_wdata,
    output logic [WAY_W-1:0]  l1_req_way,
    output logic              l1_req_skip_tag,
    input  logic              l1_resp_valid,
    input  logic [LINE_W-1:0] l1_resp_rdata,
    input  logic [WAY_W-1:0]  l1_resp_way
);
    import fdc_pkg::*;

    fdc_state_t state, state_nx;

    logic              q_we, q_byp, q_alloc;
    logic [ADDR_W-1:0] q_addr;
    logic [WORD_W-1:0] q_wdata, q_resp;
    logic [PIDX_W-1:0] q_pidx;

    logic [IDX_W-1:0]  q_idx;
    logic [TAG_W-1:0]  q_tag;
    logic [SEL_W-1:0]  q_sel;
    logic [PIDX_W-1:0] req_pidx, look_idx;
    logic              accept, hit, alloc_now;

    logic              look_miss, look_reuse;
    logic              upd_en, set_en, clr_en;
    logic              rd_valid, rd_dirty, rd_reused;
    logic [TAG_W-1:0]  rd_tag;
    logic [WAY_W-1:0]  rd_way;
    logic [PIDX_W-1:0] rd_owner;
    logic [LINE_W-1:0] rd_line;
    logic              wr_en, touch_en, fill_en;

    // Field extraction from the held request and the incoming PC
    always_comb begin
        q_idx    = q_addr[OFF_W +: IDX_W];
        q_tag    = q_addr[ADDR_W-1 -: TAG_W];
        q_sel    = q_addr[BOFF_W +: SEL_W];
        req_pidx = cpu_req_pc[2 +: PIDX_W];
        accept   = cpu_req_valid && cpu_req_ready;
        look_idx = (state == ST_IDLE) ? req_pidx : q_pidx;
        hit      = rd_valid && (rd_tag == q_tag);
        alloc_now = (state == ST_CHECK) ? look_reuse : q_alloc;
    end

    fdc_predictor #(.ENTRIES(PRED_ENTRIES)) u_pred (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_idx   (look_idx),
        .look_miss  (look_miss),
        .look_reuse (look_reuse),
        .upd_en     (upd_en),
        .upd_idx    (q_pidx),
        .upd_hit    (hit),
        .set_en     (set_en),
        .set_idx    (q_pidx),
        .clr_en     (clr_en),
        .clr_idx    (rd_owner)
    );

    fdc_lines #(
        .LINES  (LINES),
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W),
        .WORD_W (WORD_W),
        .WAY_W  (WAY_W),
        .OWN_W  (PIDX_W)
    ) u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (q_idx),
        .rd_valid   (rd_valid),
        .rd_dirty   (rd_dirty),
        .rd_reused  (rd_reused),
        .rd_tag     (rd_tag),
        .rd_way     (rd_way),
        .rd_owner   (rd_owner),
        .rd_line    (rd_line),
        .wr_en      (wr_en),
        .wr_idx     (q_idx),
        .wr_sel     (q_sel),
        .wr_word    (q_wdata),
        .touch_en   (touch_en),
        .touch_idx  (q_idx),
        .fill_en    (fill_en),
        .fill_idx   (q_idx),
        .fill_tag   (q_tag),
        .fill_way   (l1_resp_way),
        .fill_owner (q_pidx),
        .fill_line  (l1_resp_rdata)
    );

    // Next state and per-state strobes
    always_comb begin
        state_nx = state;
        upd_en   = 1'b0;
        wr_en    = 1'b0;
        touch_en = 1'b0;
        fill_en  = 1'b0;
        set_en   = 1'b0;
        clr_en   = 1'b0;
        unique case (state)
            ST_IDLE: if (accept) state_nx = ST_CHECK;
            ST_CHECK: begin
                upd_en = 1'b1;
                if (hit) begin
                    wr_en    = q_we;
                    touch_en = !q_we;
                    state_nx = ST_IDLE;
                end else if (!q_byp) begin
                    state_nx = ST_DELAY;
                end else if (q_we) begin
                    state_nx = ST_WORD;
                end else begin
                    state_nx = (alloc_now && rd_valid && rd_dirty) ? ST_WB : ST_FILL;
                end
            end
            ST_DELAY: begin
                if (q_we) state_nx = ST_WORD;
                else      state_nx = (alloc_now && rd_valid && rd_dirty) ? ST_WB : ST_FILL;
            end
            ST_WB:   if (l1_resp_valid) state_nx = ST_FILL;
            ST_FILL: begin
                if (l1_resp_valid) begin
                    fill_en  = q_alloc;
                    clr_en   = q_alloc && rd_valid && !rd_reused;
                    set_en   = !q_alloc;
                    state_nx = ST_RESP;
                end
            end
            ST_WORD: if (l1_resp_valid) state_nx = ST_RESP;
            ST_RESP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Request capture, allocation decision and miss response data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_we    <= 1'b0;
            q_byp   <= 1'b0;
            q_alloc <= 1'b0;
            q_addr  <= '0;
            q_wdata <= '0;
            q_pidx  <= '0;
            q_resp  <= '0;
        end else begin
            if (accept) begin
                q_we    <= cpu_req_we;
                q_byp   <= look_miss;
                q_addr  <= cpu_req_addr;
                q_wdata <= cpu_req_wdata;
                q_pidx  <= req_pidx;
            end
            if (state == ST_CHECK) q_alloc <= look_reuse;
            if (state == ST_FILL && l1_resp_valid) q_resp <= l1_resp_rdata[q_sel*WORD_W +: WORD_W];
            if (state == ST_WORD && l1_resp_valid) q_resp <= '0;
        end
    end

    // CPU-side outputs
    always_comb begin
        cpu_req_ready  = (state == ST_IDLE);
        cpu_resp_valid = (state == ST_RESP) || (state == ST_CHECK && hit);
        if (state == ST_RESP)     cpu_resp_rdata = q_resp;
        else if (q_we)            cpu_resp_rdata = '0;
        else                      cpu_resp_rdata = rd_line[q_sel*WORD_W +: WORD_W];
    end

    // L1-side outputs: write-back, fill read or word write
    always_comb begin
        l1_req_valid    = 1'b0;
        l1_req_op       = L1_RD_LINE;
        l1_req_addr     = {q_tag, q_idx, {OFF_W{1'b0}}};
        l1_req_wdata    = '0;
        l1_req_way      = '0;
        l1_req_skip_tag = 1'b0;
        unique case (state)
            ST_WB: begin
                l1_req_valid    = 1'b1;
                l1_req_op       = L1_WR_LINE;
                l1_req_addr     = {rd_tag, q_idx, {OFF_W{1'b0}}};
                l1_req_wdata    = rd_line;
                l1_req_way      = rd_way;
                l1_req_skip_tag = 1'b1;
            end
            ST_FILL: l1_req_valid = 1'b1;
            ST_WORD: begin
                l1_req_valid = 1'b1;
                l1_req_op    = L1_WR_WORD;
                l1_req_addr  = q_addr;
                l1_req_wdata = {{(LINE_W-WORD_W){1'b0}}, q_wdata};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fdc_checker.sv
// Port-level protocol checks for l0_filter_dcache, attached by bind.
module fdc_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic              cpu_req_ready,
    input logic              cpu_resp_valid,
    input logic              l1_req_valid,
    input logic [1:0]        l1_req_op,
    input logic [ADDR_W-1:0] l1_req_addr,
    input logic              l1_req_skip_tag,
    input logic              l1_resp_valid
);

    // R11: after acceptance the port stays busy
    p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

    // R11: response and ready never coincide; ready returns right after
    p_resp_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_valid |-> !cpu_req_ready);
    p_ready_after_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_valid |=> cpu_req_ready);

    // R1: an idle block drives no L1 request
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_ready |-> !l1_req_valid);

    // R5: no L1 request in the cycle right after acceptance
    p_no_early_l1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready) |=> !l1_req_valid);

    // R9: skip-tag flag only and always on line writes
    p_skip_only_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_req_valid && l1_req_skip_tag) |-> (l1_req_op == 2'd2));
    p_wb_skips_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_req_valid && l1_req_op == 2'd2) |-> l1_req_skip_tag);

    // R7: an L1 request holds steady until answered
    p_l1_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_req_valid && !l1_resp_valid) |=>
            (l1_req_valid && $stable(l1_req_op) && $stable(l1_req_addr)));

endmodule

bind l0_filter_dcache fdc_checker #(.ADDR_W(ADDR_W)) u_fdc_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cpu_req_valid   (cpu_req_valid),
    .cpu_req_ready   (cpu_req_ready),
    .cpu_resp_valid  (cpu_resp_valid),
    .l1_req_valid    (l1_req_valid),
    .l1_req_op       (l1_req_op),
    .l1_req_addr     (l1_req_addr),
    .l1_req_skip_tag (l1_req_skip_tag),
    .l1_resp_valid   (l1_resp_valid)
);

// File: tb/sim_l0_filter_dcache.sv
// Directed bench for l0_filter_dcache with a two-cycle L1 model.
module sim_l0_filter_dcache;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req_valid = 1'b0;
    logic         cpu_req_ready;
    logic         cpu_req_we = 1'b0;
    logic [31:0]  cpu_req_addr = '0;
    logic [31:0]  cpu_req_wdata = '0;
    logic [31:0]  cpu_req_pc = '0;
    logic         cpu_resp_valid;
    logic [31:0]  cpu_resp_rdata;
    logic         l1_req_valid;
    logic [1:0]   l1_req_op;
    logic [31:0]  l1_req_addr;
    logic [127:0] l1_req_wdata;
    logic [1:0]   l1_req_way;
    logic         l1_req_skip_tag;
    logic         l1_resp_valid = 1'b0;
    logic [127:0] l1_resp_rdata = '0;
    logic [1:0]   l1_resp_way = '0;

    l0_filter_dcache u0 (.*);

    always #2 clk = ~clk;   // 250 MHz

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Reference word memory and L1 line memory (1 KB window)
    logic [31:0]  ref_mem [256];
    logic [127:0] l1_mem  [64];

    function automatic logic [31:0] pat(input int a);
        return 32'hA000_0000 | 32'(a[9:2]);
    endfunction

    // L1 model state and first-request log
    logic        busy = 1'b0;
    int          cnt = 0;
    int          n_l1 = 0;
    logic        seen = 1'b0;
    int          f_cyc = 0;
    logic [1:0]  f_op = '0;
    logic [31:0] f_addr = '0;
    logic [1:0]  f_way = '0;
    logic        f_skip = 1'b0;
    logic [127:0] f_data = '0;
    logic [31:0] cur_addr = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            busy = 1'b0;
            l1_resp_valid = 1'b0;
        end else if (l1_resp_valid) begin
            l1_resp_valid = 1'b0;
            busy = 1'b0;
        end else if (busy) begin
            if (cnt == 0) begin
                l1_resp_valid = 1'b1;
                l1_resp_rdata = l1_mem[cur_addr[9:4]];
                l1_resp_way   = cur_addr[8:7] ^ 2'b01;
            end else cnt = cnt - 1;
        end else if (l1_req_valid) begin
            busy = 1'b1;
            cnt = 1;
            cur_addr = l1_req_addr;
            n_l1++;
            if (!seen) begin
                seen = 1'b1;
                f_cyc = cyc; f_op = l1_req_op; f_addr = l1_req_addr;
                f_way = l1_req_way; f_skip = l1_req_skip_tag; f_data = l1_req_wdata;
            end
            if (l1_req_op == 2'd2) l1_mem[l1_req_addr[9:4]] = l1_req_wdata;
            if (l1_req_op == 2'd1) l1_mem[l1_req_addr[9:4]][l1_req_addr[3:2]*32 +: 32] = l1_req_wdata[31:0];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One request; returns latency from acceptance to response and data
    int          lat = 0;
    int          acc = 0;
    logic [31:0] got = '0;
    task automatic do_req(input int pc, input int addr, input bit we, input logic [31:0] wd);
        seen = 1'b0;
        n_l1 = 0;
        cpu_req_valid = 1'b1; cpu_req_we = we;
        cpu_req_addr = 32'(addr); cpu_req_wdata = wd; cpu_req_pc = 32'(pc);
        while (!cpu_req_ready) @(negedge clk);
        acc = cyc;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        while (!cpu_resp_valid) @(negedge clk);
        got = cpu_resp_rdata;
        lat = cyc - acc;
        if (we) ref_mem[addr[9:2]] = wd;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(cpu_req_ready === 1'b1, "R1 ready", 128'(cpu_req_ready), 1);
        chk(cpu_resp_valid === 1'b0 && l1_req_valid === 1'b0, "R1 idle outputs",
            128'({cpu_resp_valid, l1_req_valid}), 0);
    endtask

    task automatic t_first_miss();
        do_req(32'h04, 32'h040, 0, 0);
        chk(f_cyc - acc == 3, "R5 lookup-path L1 delay", 128'(f_cyc - acc), 3);
        chk(f_op == 2'd0 && f_skip == 1'b0, "R7 line read op", 128'({f_op, f_skip}), 0);
        chk(f_addr == 32'h040, "R7 line address", 128'(f_addr), 128'h40);
        chk(got == ref_mem[8'h10], "R7 miss data", 128'(got), 128'(ref_mem[8'h10]));
        chk(lat == 6, "R7 response one cycle after L1", 128'(lat), 6);
    endtask

    task automatic t_hits();
        do_req(32'h04, 32'h044, 0, 0);
        chk(lat == 1 && n_l1 == 0, "R2 hit timing, no L1", 128'({lat, n_l1}), 128'({32'd1, 32'd0}));
        chk(got == ref_mem[8'h11], "R2 hit data", 128'(got), 128'(ref_mem[8'h11]));
        do_req(32'h04, 32'h048, 1, 32'h1111_2222);
        chk(lat == 1 && n_l1 == 0, "R3 store hit no L1", 128'({lat, n_l1}), 128'({32'd1, 32'd0}));
        do_req(32'h04, 32'h048, 0, 0);
        chk(got == 32'h1111_2222, "R3 read back", 128'(got), 128'h1111_2222);
    endtask

    task automatic t_dirty_evict();
        do_req(32'h08, 32'h0C0, 0, 0);
        chk(f_op == 2'd2 && f_skip == 1'b1, "R9 write-back op and skip", 128'({f_op, f_skip}), 128'({2'd2, 1'b1}));
        chk(f_addr == 32'h040 && f_way == 2'd1, "R9 victim address and way",
            128'({f_addr, f_way}), 128'({32'h040, 2'd1}));
        chk(f_data[95:64] == 32'h1111_2222, "R9 written-back word", 128'(f_data[95:64]), 128'h1111_2222);
        chk(got == ref_mem[8'h30], "R7 data after write-back", 128'(got), 128'(ref_mem[8'h30]));
    endtask

    task automatic t_store_miss();
        do_req(32'h0C, 32'h100, 1, 32'h3333_4444);
        chk(f_op == 2'd1 && f_addr == 32'h100, "R10 word write op", 128'({f_op, f_addr}), 128'({2'd1, 32'h100}));
        chk(f_data[31:0] == 32'h3333_4444, "R10 word write data", 128'(f_data[31:0]), 128'h3333_4444);
        do_req(32'h10, 32'h100, 0, 0);
        chk(n_l1 == 1 && got == 32'h3333_4444, "R10 not allocated", 128'({n_l1, got}), 128'({32'd1, 32'h3333_4444}));
    endtask

    task automatic t_select_alloc();
        do_req(32'h14, 32'h200, 0, 0);          // evicts unreused line of pc 0x10
        do_req(32'h10, 32'h140, 0, 0);          // fill suppressed
        chk(got == ref_mem[8'h50], "R8 suppressed fill data", 128'(got), 128'(ref_mem[8'h50]));
        do_req(32'h1C, 32'h140, 0, 0);
        chk(n_l1 == 1, "R8 suppressed fill left L0 unchanged", 128'(n_l1), 1);
        do_req(32'h10, 32'h1C0, 0, 0);          // counter 2: predicted miss, allocates
        chk(f_cyc - acc == 2, "R5 predicted-miss L1 delay", 128'(f_cyc - acc), 2);
        chk(lat == 5, "R4 counter reached prediction", 128'(lat), 5);
        do_req(32'h20, 32'h1C4, 0, 0);
        chk(lat == 1 && n_l1 == 0, "R8 retried fill allocated", 128'({lat, n_l1}), 128'({32'd1, 32'd0}));
    endtask

    task automatic t_bypass_hit();
        do_req(32'h10, 32'h1C8, 1, 32'h5555_6666);   // counter 3: predicted miss
        chk(lat == 1 && n_l1 == 0, "R6 bypassed store served by L0", 128'({lat, n_l1}), 128'({32'd1, 32'd0}));
        do_req(32'h10, 32'h1C8, 0, 0);               // counter 2: predicted miss
        chk(got == 32'h5555_6666 && n_l1 == 0, "R6 bypassed load returns latest",
            128'({n_l1, got}), 128'({32'd0, 32'h5555_6666}));
        do_req(32'h10, 32'h2C0, 0, 0);               // counter 1: lookup path
        chk(f_cyc - acc == 3, "R4 counter decremented by hits", 128'(f_cyc - acc), 3);
        chk(f_op == 2'd2 && f_way == 2'd2 && f_addr == 32'h1C0, "R9 second write-back way",
            128'({f_op, f_way, f_addr}), 128'({2'd2, 2'd2, 32'h1C0}));
        chk(f_data[95:64] == 32'h5555_6666, "R9 bypass-stored word written back",
            128'(f_data[95:64]), 128'h5555_6666);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = pat(i * 4);
        for (int i = 0; i < 64; i++)
            for (int w = 0; w < 4; w++) l1_mem[i][w*32 +: 32] = pat(i * 16 + w * 4);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_miss();
        t_hits();
        t_dirty_evict();
        t_store_miss();
        t_select_alloc();
        t_bypass_hit();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule